// File: doc/BRIEF.md
# Parallel Port Strobe Handshake Controller

This block manages two byte-wide parallel ports and a pair of handshake lines. One port is output-only. The other port is bidirectional, and each of its bits is set to input or output by its own direction bit. The handshake lines are a strobe input from the outside world and a strobe output to it. A single control register selects the operating mode:

- **Simple strobed mode.** Every write to the output port fires a fixed-length strobe pulse. Independently, each selected edge on the strobe input captures the bidirectional port into a latch register.
- **Full input handshake.** The strobe output means "ready to accept data". It is dropped when data is captured and raised again when software reads the latch.
- **Full output handshake.** The strobe output means "data available". It is raised by a software write to the latch and dropped by the external acknowledge.
- **Tri-state variant of output handshake.** Input-direction pins drive the latch data only while the acknowledge is held active.

The strobe input first passes through a synchronizer. Each selected edge sets a status flag, and that flag can raise an interrupt request. Software clears the flag with a two-step sequence: read the control register while the flag is set, then access the latch register. All register accesses go through a small single-cycle bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `pio_hshake`

## Requirements
- R1: In simple mode (control bit 5 = 0), a write to the output port register (address 2) makes the strobe active for exactly the two clocks after the write edge. The written byte appears on `pb_out` one clock after the write.
- R2: Control bit 2 inverts the strobe pin. The pin level is the active state XOR this bit, so with bit 2 set the pin idles high and pulses low.
- R3: A further output port write during a pulse restarts it. The strobe then stays active for exactly two clocks after the latest write.
- R4: Control bit 3 selects the active strobe-input edge (1 = rising, 0 = falling); the other edge has no effect. The strobe input passes through two synchronizer flops. The third clock edge after a pin change captures `pc_in` into the latch (address 3) in simple and full input modes.
- R5: An active edge sets the flag. The flag is read back as bit 7 of the control register (address 0). `irq` equals the flag ANDed with control bit 6.
- R6: Reading the control register while the flag is set, followed later by any latch access, clears the flag. A latch access without that prior read leaves the flag set.
- R7: Full input mode (bit 5 = 1, bit 4 = 0). Writing the control register makes the strobe active. An active edge negates it. A latch read reactivates it one clock later.
- R8: Full output mode (bit 5 = 1, bit 4 = 1, bit 1 = 0). A latch write activates the strobe and also loads the port C data register. An active edge negates the strobe.
- R9: Tri-state variant (bits 5, 4 and 1 set). Input-direction port C bits are enabled, carrying the latch data, only while the synchronized strobe input is at its active level. The strobe is negated by the trailing (inactive-going) edge.
- R10: Outside the tri-state variant, `pc_oe` equals the direction register (address 4, 1 = output). Output bits carry the port C data register (address 1). Reading address 1 returns pin levels for input bits and register bits for output bits.
- R11: Reset clears the control register, the flag and the direction register. The strobe pin is low and `pc_oe` is zero.
- R12: A latch write outside the two output handshake modes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access (reads have side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pb_out | output | 8 | Output port pins |
| pc_in | input | 8 | Bidirectional port pin levels |
| pc_out | output | 8 | Bidirectional port drive values |
| pc_oe | output | 8 | Bidirectional port output enables |
| stra_in | input | 1 | Asynchronous strobe input |
| strb_out | output | 1 | Strobe output pin |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, the output port and flag-driven `irq` change one clock after the access edge. A latch read restores the input-mode strobe one clock after the read. A strobe-input pin change reaches the tri-state enables after two clocks and the latch, flag and handshake strobe after three. The bench runs a behavioural reference model that delays the strobe input through a sample history, and compares every output half a clock after each edge. The directed checks wait exactly these counts. For R4 and R9 they also check one clock early, so that an off-by-one in the synchronizer is visible.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;

    localparam int AW = 3;

    localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADDR_PC   = 3'd1;
    localparam logic [AW-1:0] ADDR_PB   = 3'd2;
    localparam logic [AW-1:0] ADDR_LAT  = 3'd3;
    localparam logic [AW-1:0] ADDR_DDR  = 3'd4;

    // Control bits 6..1 in register order; bit 7 reads the flag.
    typedef struct packed {
        logic irq_en;
        logic hs_en;
        logic out_hs;
        logic edge_rise;
        logic strb_inv;
        logic tri_var;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_SIMPLE,
        MODE_IN_HS,
        MODE_OUT_HS,
        MODE_OUT_TRI
    } mode_e;

    function automatic mode_e mode_of(ctrl_t c);
        if (!c.hs_en)   return MODE_SIMPLE;
        if (!c.out_hs)  return MODE_IN_HS;
        if (!c.tri_var) return MODE_OUT_HS;
        return MODE_OUT_TRI;
    endfunction

    function automatic logic [7:0] ctrl_view(logic flag, ctrl_t c);
        return {flag, c, 1'b0};
    endfunction

endpackage

// File: rtl/pio_hs_sync.sv
module pio_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_sel,
    output logic act_edge,
    output logic trail_edge,
    output logic active
);

    logic [STAGES-1:0] chain;
    logic              prev;
    logic              lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl        = chain[STAGES-1];
    assign act_edge   = rise_sel ? (lvl & ~prev) : (~lvl & prev);
    assign trail_edge = rise_sel ? (~lvl & prev) : (lvl & ~prev);
    assign active     = rise_sel ? lvl : ~lvl;

endmodule

// File: rtl/pio_hs_strobe.sv
module pio_hs_strobe
    import pio_hs_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  ctrl_wr,
    input  mode_e mode_nxt,
    input  logic  pb_wr,
    input  logic  lat_rd,
    input  logic  lat_wr,
    input  logic  act_edge,
    input  logic  trail_edge,
    input  logic  inv,
    output logic  strb_act,
    output logic  strb_pin
);

    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt;
    logic          rdy;
    logic          rdy_nxt;

    always_comb begin
        rdy_nxt = rdy;
        if (ctrl_wr) begin
            rdy_nxt = (mode_nxt == MODE_IN_HS);
        end else begin
            case (mode)
                MODE_IN_HS:   if (lat_rd) rdy_nxt = 1'b1; else if (act_edge)   rdy_nxt = 1'b0;
                MODE_OUT_HS:  if (lat_wr) rdy_nxt = 1'b1; else if (act_edge)   rdy_nxt = 1'b0;
                MODE_OUT_TRI: if (lat_wr) rdy_nxt = 1'b1; else if (trail_edge) rdy_nxt = 1'b0;
                default:      rdy_nxt = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else begin
            rdy <= rdy_nxt;
            if (pb_wr && mode == MODE_SIMPLE) begin
                cnt <= CW'(PULSE_LEN);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign strb_act = (mode == MODE_SIMPLE) ? (cnt != '0) : rdy;
    assign strb_pin = strb_act ^ inv;

endmodule

// File: rtl/pio_hs_pad.sv
module pio_hs_pad #(
    parameter int W = 8
) (
    input  logic [W-1:0] ddr,
    input  logic [W-1:0] pc_reg,
    input  logic [W-1:0] latch,
    input  logic         tri_drive,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pc_oe[i]  = ddr[i] | tri_drive;
        assign pc_out[i] = ddr[i] ? pc_reg[i] : latch[i];
    end

endmodule

// File: rtl/pio_hshake.sv
module pio_hshake
    import pio_hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pb_out,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe,
    input  logic              stra_in,
    output logic              strb_out,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic              flag_q, arm_q;
    logic [DATA_W-1:0] pb_q, pc_q, lat_q, ddr_q;
    mode_e             mode, mode_nxt;
    logic              act_edge, trail_edge, tri_active;
    logic              strb_act;
    logic              wr_ctrl, rd_ctrl, wr_pc, wr_pb, wr_ddr, wr_lat, rd_lat, lat_acc;
    logic              out_mode, in_capture;

    assign wr_ctrl  = bus_wr && bus_addr == ADDR_CTRL;
    assign rd_ctrl  = bus_rd && bus_addr == ADDR_CTRL;
    assign wr_pc    = bus_wr && bus_addr == ADDR_PC;
    assign wr_pb    = bus_wr && bus_addr == ADDR_PB;
    assign wr_ddr   = bus_wr && bus_addr == ADDR_DDR;
    assign wr_lat   = bus_wr && bus_addr == ADDR_LAT;
    assign rd_lat   = bus_rd && bus_addr == ADDR_LAT;
    assign lat_acc  = wr_lat || rd_lat;

    assign mode       = mode_of(ctrl_q);
    assign mode_nxt   = mode_of(ctrl_t'(bus_wdata[6:1]));
    assign out_mode   = (mode == MODE_OUT_HS) || (mode == MODE_OUT_TRI);
    assign in_capture = act_edge && !out_mode;

    pio_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .din        (stra_in),
        .rise_sel   (ctrl_q.edge_rise),
        .act_edge   (act_edge),
        .trail_edge (trail_edge),
        .active     (tri_active)
    );

    pio_hs_strobe #(.PULSE_LEN(PULSE_LEN)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .ctrl_wr    (wr_ctrl),
        .mode_nxt   (mode_nxt),
        .pb_wr      (wr_pb),
        .lat_rd     (rd_lat),
        .lat_wr     (wr_lat),
        .act_edge   (act_edge),
        .trail_edge (trail_edge),
        .inv        (ctrl_q.strb_inv),
        .strb_act   (strb_act),
        .strb_pin   (strb_out)
    );

    pio_hs_pad #(.W(DATA_W)) u_pad (
        .ddr       (ddr_q),
        .pc_reg    (pc_q),
        .latch     (lat_q),
        .tri_drive (mode == MODE_OUT_TRI && tri_active),
        .pc_out    (pc_out),
        .pc_oe     (pc_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
            pb_q   <= '0;
            pc_q   <= '0;
            lat_q  <= '0;
            ddr_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[6:1]);
            if (wr_pb)   pb_q   <= bus_wdata;
            if (wr_ddr)  ddr_q  <= bus_wdata;

            if (wr_lat && out_mode) begin
                lat_q <= bus_wdata;
                pc_q  <= bus_wdata;
            end else begin
                if (wr_pc)      pc_q  <= bus_wdata;
                if (in_capture) lat_q <= pc_in;
            end

            if (act_edge)               flag_q <= 1'b1;
            else if (lat_acc && arm_q)  flag_q <= 1'b0;

            if (rd_ctrl && flag_q) arm_q <= 1'b1;
            else if (lat_acc)      arm_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata[7:0] = ctrl_view(flag_q, ctrl_q);
            ADDR_PC:   bus_rdata = (pc_in & ~ddr_q) | (pc_q & ddr_q);
            ADDR_PB:   bus_rdata = pb_q;
            ADDR_LAT:  bus_rdata = lat_q;
            ADDR_DDR:  bus_rdata = ddr_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pb_out = pb_q;
    assign irq    = flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/pio_hs_chk.sv
module pio_hs_chk
    import pio_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [AW-1:0]     bus_addr,
    input mode_e             mode,
    input logic              strb_act,
    input logic              act_edge,
    input logic              flag,
    input logic [DATA_W-1:0] latch,
    input logic [DATA_W-1:0] pc_in,
    input logic [DATA_W-1:0] pc_oe,
    input logic [DATA_W-1:0] ddr,
    input logic              tri_active
);

    logic pbw, ctw, latrd;
    assign pbw   = bus_wr && bus_addr == ADDR_PB;
    assign ctw   = bus_wr && bus_addr == ADDR_CTRL;
    assign latrd = bus_rd && bus_addr == ADDR_LAT;

    // R1
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        (pbw && mode == MODE_SIMPLE) |=> strb_act);

    // R1
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SIMPLE && $past(mode == MODE_SIMPLE) && strb_act && $past(strb_act)
         && !pbw && !$past(pbw) && !ctw) |=> !strb_act);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        act_edge |=> flag);

    // R4
    latch_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (act_edge && (mode == MODE_SIMPLE || mode == MODE_IN_HS)) |=> (latch == $past(pc_in)));

    // R7
    in_negate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IN_HS && act_edge && !latrd && !ctw) |=> !strb_act);

    // R9
    tri_idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OUT_TRI && !tri_active) |-> (pc_oe == ddr));

endmodule

bind pio_hshake pio_hs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .mode       (mode),
    .strb_act   (strb_act),
    .act_edge   (act_edge),
    .flag       (flag_q),
    .latch      (lat_q),
    .pc_in      (pc_in),
    .pc_oe      (pc_oe),
    .ddr        (ddr_q),
    .tri_active (tri_active)
);

// File: tb/pio_hshake_tb.sv
module pio_hshake_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pc_in = '0;
    logic       stra_in = 1'b0;
    logic [7:0] bus_rdata, pb_out, pc_out, pc_oe;
    logic       strb_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio_hshake u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pb_out(pb_out), .pc_in(pc_in),
        .pc_out(pc_out), .pc_oe(pc_oe), .stra_in(stra_in), .strb_out(strb_out), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, stepped on each rising edge.
    bit m_ie, m_hs, m_out, m_rise, m_inv, m_tri, m_flag, m_arm, m_rdy;
    bit h1, h2, h3;
    int m_cnt;
    logic [7:0] m_pb, m_pcr, m_lat, m_ddr;

    always @(posedge clk) begin
        if (rst) begin
            {m_ie, m_hs, m_out, m_rise, m_inv, m_tri, m_flag, m_arm, m_rdy} = '0;
            {h1, h2, h3} = '0;
            m_cnt = 0;
            m_pb = 0; m_pcr = 0; m_lat = 0; m_ddr = 0;
        end else begin
            bit ae, te, lacc, nflag, narm, nrdy;
            int ncnt;
            logic [7:0] nlat, npcr;
            ae   = m_rise ? (h2 && !h3) : (!h2 && h3);
            te   = m_rise ? (!h2 && h3) : (h2 && !h3);
            lacc = (bus_rd || bus_wr) && bus_addr == 3;
            nflag = ae ? 1'b1 : ((lacc && m_arm) ? 1'b0 : m_flag);
            narm  = (bus_rd && bus_addr == 0 && m_flag) ? 1'b1 : (lacc ? 1'b0 : m_arm);
            nlat = m_lat; npcr = m_pcr;
            if (bus_wr && bus_addr == 1) npcr = bus_wdata;
            if (ae && !(m_hs && m_out)) nlat = pc_in;
            if (bus_wr && bus_addr == 3 && m_hs && m_out) begin nlat = bus_wdata; npcr = bus_wdata; end
            ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (bus_wr && bus_addr == 2 && !m_hs) ncnt = 2;
            if (bus_wr && bus_addr == 0)  nrdy = bus_wdata[5] && !bus_wdata[4];
            else if (!m_hs)               nrdy = 1'b0;
            else if (!m_out)              nrdy = (bus_rd && bus_addr == 3) ? 1'b1 : (ae ? 1'b0 : m_rdy);
            else if (!m_tri)              nrdy = (bus_wr && bus_addr == 3) ? 1'b1 : (ae ? 1'b0 : m_rdy);
            else                          nrdy = (bus_wr && bus_addr == 3) ? 1'b1 : (te ? 1'b0 : m_rdy);
            if (bus_wr && bus_addr == 0)
                {m_ie, m_hs, m_out, m_rise, m_inv, m_tri} = bus_wdata[6:1];
            if (bus_wr && bus_addr == 2) m_pb = bus_wdata;
            if (bus_wr && bus_addr == 4) m_ddr = bus_wdata;
            m_flag = nflag; m_arm = narm; m_rdy = nrdy; m_cnt = ncnt;
            m_lat = nlat; m_pcr = npcr;
            h3 = h2; h2 = h1; h1 = stra_in;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit act, lvl;
            #1;
            act = m_hs ? m_rdy : (m_cnt != 0);
            lvl = m_rise ? h2 : !h2;
            chk("R1/R2/R3/R7/R8/R9 model strb", strb_out, act ^ m_inv);
            chk("R5 model irq", irq, m_flag && m_ie);
            chk("R9/R10 model pc_oe", pc_oe, m_ddr | ((m_hs && m_out && m_tri && lvl) ? 8'hFF : 8'h00));
            chk("R8/R10 model pc_out", pc_out, (m_ddr & m_pcr) | (~m_ddr & m_lat));
            chk("R1 model pb_out", pb_out, m_pb);
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #2 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(tag, bus_rdata, exp);
        @(negedge clk); #2 bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst = 1'b0;
        // R11 reset state
        chk("R11 strb after reset", strb_out, 0);
        chk("R11 irq after reset", irq, 0);
        chk("R11 pc_oe after reset", pc_oe, 0);
        rd(0, 8'h00, "R11 ctrl after reset");
        rd(4, 8'h00, "R11 ddr after reset");

        // R10 static port C
        wr(4, 8'h0F); wr(1, 8'hA5); pc_in = 8'h3C;
        rd(1, 8'h35, "R10 port C mixed read");
        chk("R10 pc_oe follows ddr", pc_oe, 8'h0F);
        chk("R10 output bits", pc_out & 8'h0F, 8'h05);

        // R1 simple pulse
        wr(2, 8'h55);
        chk("R1 pulse cycle 1", strb_out, 1);
        chk("R1 pb_out", pb_out, 8'h55);
        idle(1); chk("R1 pulse cycle 2", strb_out, 1);
        idle(1); chk("R1 pulse over", strb_out, 0);

        // R3 restart
        wr(2, 8'h11); idle(1); wr(2, 8'h22);
        chk("R3 restarted", strb_out, 1);
        idle(1); chk("R3 second cycle", strb_out, 1);
        idle(1); chk("R3 ended two after last write", strb_out, 0);

        // R2 inverted polarity
        wr(0, 8'h04);
        chk("R2 idle high", strb_out, 1);
        wr(2, 8'h33); chk("R2 low pulse 1", strb_out, 0);
        idle(1); chk("R2 low pulse 2", strb_out, 0);
        idle(1); chk("R2 back high", strb_out, 1);

        // R4/R5/R6 rising edge capture, flag, irq, clear
        wr(0, 8'h48); pc_in = 8'h9E; stra_in = 1'b1;
        idle(2); chk("R4 not before third edge", irq, 0);
        idle(1); chk("R5 irq on flag", irq, 1);
        rd(3, 8'h9E, "R4 latched on rising");
        chk("R6 no clear without ctrl read", irq, 1);
        rd(0, 8'hC8, "R5 flag bit 7");
        rd(3, 8'h9E, "R6 latch access after read");
        chk("R6 flag cleared", irq, 0);
        pc_in = 8'h11; stra_in = 1'b0; idle(4);
        chk("R4 falling ignored in rise mode", irq, 0);
        rd(3, 8'h9E, "R4 latch unchanged");
        wr(0, 8'h40); stra_in = 1'b1; idle(4);
        chk("R4 rising ignored in fall mode", irq, 0);
        pc_in = 8'h77; stra_in = 1'b0; idle(3);
        chk("R4 falling edge flags", irq, 1);
        rd(0, 8'hC0, "R5 flag in fall mode");
        rd(3, 8'h77, "R4 falling captured");
        chk("R6 cleared again", irq, 0);

        // R7 full input handshake
        wr(0, 8'h28);
        chk("R7 ready on entry", strb_out, 1);
        pc_in = 8'h61; stra_in = 1'b1;
        idle(2); chk("R7 still ready", strb_out, 1);
        idle(1); chk("R7 negated on edge", strb_out, 0);
        rd(3, 8'h61, "R7 latched data");
        chk("R7 reasserted after read", strb_out, 1);
        stra_in = 1'b0; idle(3);

        // R12 latch write ignored in input mode
        wr(3, 8'hFF);
        rd(3, 8'h61, "R12 latch write ignored");

        // R8 full output handshake
        wr(0, 8'h38);
        chk("R8 idle", strb_out, 0);
        wr(3, 8'hC3);
        chk("R8 data ready", strb_out, 1);
        chk("R8 pc_out", pc_out, 8'hC3);
        rd(1, 8'h63, "R8 port C register loaded");
        stra_in = 1'b1; idle(3);
        chk("R8 ack negates", strb_out, 0);
        stra_in = 1'b0; idle(3);

        // R9 tri-state variant
        wr(0, 8'h3A); wr(3, 8'h5A);
        chk("R9 strobe ready", strb_out, 1);
        chk("R9 no drive idle", pc_oe, 8'h0F);
        stra_in = 1'b1;
        idle(1); chk("R9 not yet driving", pc_oe, 8'h0F);
        idle(1); chk("R9 driving while active", pc_oe, 8'hFF);
        chk("R9 drives latch data", pc_out, 8'h5A);
        idle(2); chk("R9 strobe held while active", strb_out, 1);
        stra_in = 1'b0;
        idle(2); chk("R9 drive released", pc_oe, 8'h0F);
        idle(1); chk("R9 negated on trailing edge", strb_out, 0);

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule